// File: doc/BRIEF.md
# Dual-Mode Host Register Bus Front End

This block connects an asynchronous parallel host bus to a register file that runs on an internal clock. Two strap pins configure it. `bus_mode` chooses how the host marks its accesses. In one convention a direction line is paired with a single data strobe. In the other, separate active-low read and write strobes share the same two pins. `mux_sel` chooses where the address comes from. It is either taken from dedicated address pins, or captured from a shared address/data bus when an address latch strobe falls.

Every host input passes through a two-flop synchronizer. Strobe edges are detected in the internal clock domain, so each host access produces exactly one single-cycle read or write request, together with its address and write data. Read data returned by the register file is held on `data_out`. `data_oe` tells the pad logic when to drive the shared data bus. It is asserted only while chip select is low and a read strobe is active.

Top module: `hostbus_frontend`

## Requirements
- R1: With `bus_mode`=0, a falling edge on `ds_wr_n` while `dir_rd_n`=1 and `cs_n`=0 produces exactly one `reg_rd_req` pulse.
- R2: With `bus_mode`=0, a rising edge on `ds_wr_n` while `dir_rd_n`=0 and `cs_n`=0 produces exactly one `reg_wr_req` pulse. In that cycle `reg_wdata` equals the host data.
- R3: With `bus_mode`=1, a falling edge on `dir_rd_n` (the read strobe) while `ds_wr_n`=1 and `cs_n`=0 produces exactly one `reg_rd_req` pulse.
- R4: With `bus_mode`=1, a rising edge on `ds_wr_n` (the end of the write strobe) while `dir_rd_n`=1 and `cs_n`=0 produces exactly one `reg_wr_req` pulse carrying the host data.
- R5: While `cs_n`=1, strobe activity produces no request and never asserts `data_oe`.
- R6: With `mux_sel`=0, `reg_addr` is taken from `addr_in`. With `mux_sel`=1, it is the low ADDR_W bits of `data_in` sampled at the last falling edge of `ale`, and `addr_in` is ignored.
- R7: `data_oe` is high exactly while the synchronized inputs show `cs_n`=0 and an active read. It follows the host levels three rising edges later.
- R8: `data_out` takes the value of `reg_rdata` in the cycle `reg_rd_req` is high, and holds that value until the next read.
- R9: A request is never high two cycles in a row, and `reg_rd_req` and `reg_wr_req` are never high together.
- R10: Under reset, `reg_rd_req`, `reg_wr_req`, `data_oe`, `reg_addr`, `reg_wdata` and `data_out` are all 0.
- R11: A request is high in the clock cycle that begins at the third rising edge at which the new strobe level is present at the pin.
- R12: With `bus_mode`=1, a strobe edge that occurs while the other strobe is low produces no request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_mode | input | 1 | Strap: 0 = direction line plus data strobe, 1 = separate read/write strobes |
| mux_sel | input | 1 | Strap: 0 = separate address pins, 1 = shared bus with address latch |
| cs_n | input | 1 | Host chip select, active low |
| dir_rd_n | input | 1 | Direction line (1 = read) in mode 0; read strobe, active low, in mode 1 |
| ds_wr_n | input | 1 | Data strobe in mode 0; write strobe, active low, in mode 1 |
| ale | input | 1 | Address latch strobe; address captured on its falling edge |
| addr_in | input | ADDR_W | Dedicated host address pins |
| data_in | input | DATA_W | Host data bus as seen at the pads (also carries the address when muxed) |
| data_out | output | DATA_W | Read data to drive onto the host bus |
| data_oe | output | 1 | Pad output enable for `data_out` |
| reg_rd_req | output | 1 | Single-cycle register read request |
| reg_wr_req | output | 1 | Single-cycle register write request |
| reg_addr | output | ADDR_W | Register address of the current request |
| reg_wdata | output | DATA_W | Write data of the current write request |
| reg_rdata | input | DATA_W | Register file read data, valid combinationally for `reg_addr` |

## Verification
On every cycle, the assertions check the following:
- each request is a one-cycle pulse, and the two kinds of request never coincide;
- a read request always comes with the output enable;
- the latched multiplexed address changes only on an address strobe fall;
- the read data register changes only when a read is requested.

The bench's scenarios are needed to show the rest: that each strobe convention and both bus styles decode to the right kind of request with the right address and data, that chip select high and overlapping strobes suppress accesses, and that the three-edge latency and output-enable release follow the host pins.

// File: rtl/hb_pkg.sv
// Shared types for the host bus front end.
// Assumes nothing beyond the consumers agreeing on the field order.
package hb_pkg;

    // Access convention selected by the strap pin.
    typedef enum logic {
        BUS_DIR_STROBE = 1'b0,
        BUS_RW_STROBES = 1'b1
    } bus_mode_e;

    // Control pins of the host bus, grouped so they synchronize together.
    typedef struct packed {
        logic cs_n;
        logic dir_rd_n;
        logic ds_wr_n;
        logic ale;
    } host_ctl_t;

    localparam int CTL_W = $bits(host_ctl_t);
    localparam host_ctl_t CTL_IDLE = '{cs_n: 1'b1, dir_rd_n: 1'b1, ds_wr_n: 1'b1, ale: 1'b1};

endpackage

// File: rtl/hb_sync.sv
// Multi-stage flop synchronizer for a group of asynchronous inputs.
// Assumes multi-bit groups are held stable by the host around the strobes
// that qualify them, so bit skew between lanes is harmless.
module hb_sync #(
    parameter int           W       = 1,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // Purpose: first capture of the asynchronous input.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage[g] <= RST_VAL;
                    else        stage[g] <= d;
                end
            end else begin : g_next
                // Purpose: further resolution stages.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage[g] <= RST_VAL;
                    else        stage[g] <= stage[g-1];
                end
            end
        end
    endgenerate

    assign q = stage[STAGES-1];

endmodule

// File: rtl/hb_access_decode.sv
// Decodes synchronized host control pins into read/write events.
// Mode 0: dir_rd_n is direction (1 = read), ds_wr_n is the data strobe;
//         read on strobe fall, write on strobe rise.
// Mode 1: dir_rd_n / ds_wr_n are active-low read / write strobes;
//         read on read-strobe fall, write on write-strobe rise, each only
//         while the other strobe is high.
// Assumes bus_mode is a static strap and cs_n stays low until the strobe
// release has been synchronized.
module hb_access_decode
    import hb_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      bus_mode,
    input  host_ctl_t s_ctl,
    output logic      rd_evt,
    output logic      wr_evt,
    output logic      rd_level
);

    host_ctl_t p_ctl;

    // Purpose: keep the previous synchronized sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) p_ctl <= CTL_IDLE;
        else        p_ctl <= s_ctl;
    end

    // Purpose: turn levels and edges into access events for the chosen mode.
    always_comb begin
        rd_evt   = 1'b0;
        wr_evt   = 1'b0;
        rd_level = 1'b0;
        if (!s_ctl.cs_n) begin
            if (bus_mode_e'(bus_mode) == BUS_DIR_STROBE) begin
                rd_evt   = s_ctl.dir_rd_n  && !s_ctl.ds_wr_n && p_ctl.ds_wr_n;
                wr_evt   = !s_ctl.dir_rd_n && s_ctl.ds_wr_n  && !p_ctl.ds_wr_n;
                rd_level = s_ctl.dir_rd_n  && !s_ctl.ds_wr_n;
            end else begin
                rd_evt   = !s_ctl.dir_rd_n && p_ctl.dir_rd_n && s_ctl.ds_wr_n;
                wr_evt   = s_ctl.ds_wr_n   && !p_ctl.ds_wr_n && s_ctl.dir_rd_n;
                rd_level = !s_ctl.dir_rd_n && s_ctl.ds_wr_n;
            end
        end
    end

endmodule

// File: rtl/hb_addr_latch.sv
// Selects the access address: dedicated pins, or the shared bus value
// captured on a falling edge of the synchronized address latch strobe.
// Assumes ADDR_W <= DATA_W and that mux_sel is a static strap.
module hb_addr_latch #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mux_sel,
    input  logic              s_ale,
    input  logic [ADDR_W-1:0] s_addr,
    input  logic [DATA_W-1:0] s_data,
    output logic [ADDR_W-1:0] addr_sel
);

    logic              p_ale;
    logic [ADDR_W-1:0] latch_q;
    logic              ale_fall;

    assign ale_fall = mux_sel && p_ale && !s_ale;

    // Purpose: remember the strobe and capture the address on its fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_ale   <= 1'b1;
            latch_q <= '0;
        end else begin
            p_ale <= s_ale;
            if (ale_fall) latch_q <= s_data[ADDR_W-1:0];
        end
    end

    // Purpose: route the address source picked by the strap.
    assign addr_sel = mux_sel ? latch_q : s_addr;

    AST_LATCH_ONLY_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mux_sel && p_ale && !s_ale) |=> $stable(latch_q)); // R6

endmodule

// File: rtl/hostbus_frontend.sv
// Host bus front end: synchronizes an asynchronous parallel host bus,
// decodes either strobe convention and either address style, and issues
// single-cycle register read/write requests.
// Assumes the register file returns reg_rdata combinationally for reg_addr,
// and that the straps change only while the bus is idle.
module hostbus_frontend
    import hb_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_mode,
    input  logic              mux_sel,
    input  logic              cs_n,
    input  logic              dir_rd_n,
    input  logic              ds_wr_n,
    input  logic              ale,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic              reg_rd_req,
    output logic              reg_wr_req,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_rdata
);

    host_ctl_t         raw_ctl;
    host_ctl_t         s_ctl;
    logic [CTL_W-1:0]  s_ctl_bits;
    logic [ADDR_W-1:0] s_addr;
    logic [DATA_W-1:0] s_data;
    logic [ADDR_W-1:0] addr_sel;
    logic              rd_evt;
    logic              wr_evt;
    logic              rd_level;

    assign raw_ctl = '{cs_n: cs_n, dir_rd_n: dir_rd_n, ds_wr_n: ds_wr_n, ale: ale};

    hb_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)) u_sync_ctl (
        .clk(clk), .rst_n(rst_n), .d(raw_ctl), .q(s_ctl_bits)
    );
    assign s_ctl = host_ctl_t'(s_ctl_bits);

    hb_sync #(.W(ADDR_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_addr (
        .clk(clk), .rst_n(rst_n), .d(addr_in), .q(s_addr)
    );

    hb_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_data (
        .clk(clk), .rst_n(rst_n), .d(data_in), .q(s_data)
    );

    hb_access_decode u_decode (
        .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode), .s_ctl(s_ctl),
        .rd_evt(rd_evt), .wr_evt(wr_evt), .rd_level(rd_level)
    );

    hb_addr_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .mux_sel(mux_sel), .s_ale(s_ctl.ale),
        .s_addr(s_addr), .s_data(s_data), .addr_sel(addr_sel)
    );

    // Purpose: register request pulses, enable and the address/data payload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rd_req <= 1'b0;
            reg_wr_req <= 1'b0;
            data_oe    <= 1'b0;
            reg_addr   <= '0;
            reg_wdata  <= '0;
        end else begin
            reg_rd_req <= rd_evt;
            reg_wr_req <= wr_evt;
            data_oe    <= rd_level;
            if (rd_evt || wr_evt) reg_addr  <= addr_sel;
            if (wr_evt)           reg_wdata <= s_data;
        end
    end

    // Purpose: capture register read data for the duration of the read.
    always_ff @(posedge clk) begin
        if (!rst_n)          data_out <= '0;
        else if (reg_rd_req) data_out <= reg_rdata;
    end

    AST_RD_ONE_SHOT:   assert property (@(posedge clk) disable iff (!rst_n) reg_rd_req |=> !reg_rd_req); // R9
    AST_WR_ONE_SHOT:   assert property (@(posedge clk) disable iff (!rst_n) reg_wr_req |=> !reg_wr_req); // R9
    AST_NO_RD_AND_WR:  assert property (@(posedge clk) disable iff (!rst_n) !(reg_rd_req && reg_wr_req)); // R9
    AST_RD_DRIVES_BUS: assert property (@(posedge clk) disable iff (!rst_n) reg_rd_req |-> data_oe); // R7
    AST_DOUT_HOLDS:    assert property (@(posedge clk) disable iff (!rst_n) !reg_rd_req |=> $stable(data_out)); // R8

endmodule

// File: tb/test_hostbus_frontend.sv
`timescale 1ns/1ps
module test_hostbus_frontend;

    localparam int AW = 8;
    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_mode = 1'b0, mux_sel = 1'b0;
    logic cs_n = 1'b1, dir_rd_n = 1'b1, ds_wr_n = 1'b1, ale = 1'b1;
    logic [AW-1:0] addr_in = '0;
    logic [DW-1:0] data_in = '0;
    logic [DW-1:0] data_out, reg_wdata, reg_rdata;
    logic [AW-1:0] reg_addr;
    logic data_oe, reg_rd_req, reg_wr_req;

    always #4 clk = ~clk;

    hostbus_frontend #(.ADDR_W(AW), .DATA_W(DW)) i_hostbus_frontend (
        .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode), .mux_sel(mux_sel),
        .cs_n(cs_n), .dir_rd_n(dir_rd_n), .ds_wr_n(ds_wr_n), .ale(ale),
        .addr_in(addr_in), .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
        .reg_rd_req(reg_rd_req), .reg_wr_req(reg_wr_req), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    // Bench-side register file (stimulus) and an independent model copy.
    logic [DW-1:0] mem     [256];
    logic [DW-1:0] mdl_mem [256];
    initial for (int i = 0; i < 256; i++) begin
        mem[i]     = DW'(i * 7 + 3);
        mdl_mem[i] = DW'(i * 7 + 3);
    end
    assign reg_rdata = mem[reg_addr];
    always @(posedge clk) if (reg_wr_req) mem[reg_addr] <= reg_wdata;

    int checks = 0, errors = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference model: pin history, three-edge latency, behavioural decode.
    typedef struct packed {
        logic cs, dir, ds, al;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
    } smp_t;
    localparam smp_t IDLE_SMP = '{cs: 1'b1, dir: 1'b1, ds: 1'b1, al: 1'b1, a: '0, d: '0};
    smp_t h [4];
    logic exp_rd = 0, exp_wr = 0, exp_oe = 0;
    logic [AW-1:0] exp_addr = '0, exp_latch = '0;
    logic [DW-1:0] exp_wdata = '0, exp_dout = '0;

    always @(posedge clk) begin
        smp_t s, p;
        logic er, ew, lv;
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) h[i] = IDLE_SMP;
            exp_rd = 0; exp_wr = 0; exp_oe = 0;
            exp_addr = '0; exp_latch = '0; exp_wdata = '0; exp_dout = '0;
        end else begin
            if (exp_rd) exp_dout = mdl_mem[exp_addr];
            if (exp_wr) mdl_mem[exp_addr] = exp_wdata;
            h[3] = h[2]; h[2] = h[1]; h[1] = h[0];
            h[0] = '{cs: cs_n, dir: dir_rd_n, ds: ds_wr_n, al: ale, a: addr_in, d: data_in};
            s = h[2]; p = h[3];
            if (!bus_mode) begin
                er = !s.cs && s.dir && !s.ds && p.ds;
                ew = !s.cs && !s.dir && s.ds && !p.ds;
                lv = !s.cs && s.dir && !s.ds;
            end else begin
                er = !s.cs && !s.dir && p.dir && s.ds;
                ew = !s.cs && s.ds && !p.ds && s.dir;
                lv = !s.cs && !s.dir && s.ds;
            end
            exp_rd = er; exp_wr = ew; exp_oe = lv;
            if (er || ew) exp_addr = mux_sel ? exp_latch : s.a;
            if (ew) exp_wdata = s.d;
            if (mux_sel && p.al && !s.al) exp_latch = s.d[AW-1:0];
        end
    end

    int n_rd = 0, n_wr = 0, n_oe = 0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(reg_rd_req == exp_rd, "R11 R1 R3 rd_req timing", reg_rd_req, exp_rd);
            chk(reg_wr_req == exp_wr, "R11 R2 R4 wr_req timing", reg_wr_req, exp_wr);
            chk(data_oe == exp_oe, "R7 data_oe", data_oe, exp_oe);
            chk(reg_addr == exp_addr, "R6 reg_addr", reg_addr, exp_addr);
            chk(reg_wdata == exp_wdata, "R2 R4 reg_wdata", reg_wdata, exp_wdata);
            chk(data_out == exp_dout, "R8 data_out", data_out, exp_dout);
            if (reg_rd_req) n_rd++;
            if (reg_wr_req) n_wr++;
            if (data_oe) n_oe++;
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic m0_read(input logic [AW-1:0] a);
        cs_n = 0; dir_rd_n = 1; addr_in = a; wait_n(2);
        ds_wr_n = 0; wait_n(6); ds_wr_n = 1; wait_n(3); cs_n = 1; wait_n(4);
    endtask

    task automatic m0_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        cs_n = 0; dir_rd_n = 0; addr_in = a; data_in = d; wait_n(2);
        ds_wr_n = 0; wait_n(5); ds_wr_n = 1; wait_n(3); cs_n = 1; dir_rd_n = 1; wait_n(4);
    endtask

    task automatic m1_read(input logic [AW-1:0] a);
        cs_n = 0; addr_in = a; wait_n(2);
        dir_rd_n = 0; wait_n(6); dir_rd_n = 1; wait_n(3); cs_n = 1; wait_n(4);
    endtask

    task automatic m1_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        cs_n = 0; addr_in = a; data_in = d; wait_n(2);
        ds_wr_n = 0; wait_n(5); ds_wr_n = 1; wait_n(3); cs_n = 1; wait_n(4);
    endtask

    task automatic mux_addr(input logic [AW-1:0] a);
        ale = 1; data_in = a; addr_in = 8'hEE; wait_n(3);
        ale = 0; wait_n(3); data_in = 8'h00;
    endtask

    initial begin
        int r0, w0, o0;
        wait_n(3);
        chk(reg_rd_req == 0 && reg_wr_req == 0 && data_oe == 0, "R10 reset strobes", {reg_rd_req, reg_wr_req, data_oe}, 0);
        chk(reg_addr == 0 && reg_wdata == 0 && data_out == 0, "R10 reset data", {reg_addr, reg_wdata, data_out}, 0);
        rst_n = 1; wait_n(4);

        // Mode 0: direction plus data strobe.
        r0 = n_rd; m0_read(8'h21);
        chk(n_rd - r0 == 1, "R1 one read pulse", n_rd - r0, 1);
        chk(data_out == DW'(8'h21 * 7 + 3), "R8 mode0 read data", data_out, DW'(8'h21 * 7 + 3));
        w0 = n_wr; m0_write(8'h40, 8'h5A);
        chk(n_wr - w0 == 1, "R2 one write pulse", n_wr - w0, 1);
        chk(mem[8'h40] == 8'h5A, "R2 written value", mem[8'h40], 8'h5A);
        m0_read(8'h40);
        chk(data_out == 8'h5A, "R2 R8 readback", data_out, 8'h5A);

        // R5: chip select high blocks everything.
        r0 = n_rd; w0 = n_wr; o0 = n_oe;
        dir_rd_n = 1; ds_wr_n = 0; wait_n(5); ds_wr_n = 1; wait_n(5);
        dir_rd_n = 0; ds_wr_n = 0; wait_n(5); ds_wr_n = 1; wait_n(5); dir_rd_n = 1; wait_n(4);
        chk(n_rd == r0 && n_wr == w0, "R5 no request with cs high", n_rd + n_wr, r0 + w0);
        chk(n_oe == o0, "R5 no enable with cs high", n_oe, o0);

        // Mode 1: separate strobes.
        bus_mode = 1; wait_n(4);
        r0 = n_rd; m1_read(8'h07);
        chk(n_rd - r0 == 1, "R3 one read pulse", n_rd - r0, 1);
        chk(data_out == DW'(8'h07 * 7 + 3), "R3 R8 read data", data_out, DW'(8'h07 * 7 + 3));
        w0 = n_wr; m1_write(8'h90, 8'hC3);
        chk(n_wr - w0 == 1, "R4 one write pulse", n_wr - w0, 1);
        chk(mem[8'h90] == 8'hC3, "R4 written value", mem[8'h90], 8'hC3);

        // R12: overlapping strobes give nothing.
        r0 = n_rd; w0 = n_wr;
        cs_n = 0; addr_in = 8'h11; wait_n(2);
        ds_wr_n = 0; wait_n(4); dir_rd_n = 0; wait_n(4);
        ds_wr_n = 1; wait_n(4); dir_rd_n = 1; wait_n(4); cs_n = 1; wait_n(4);
        chk(n_rd == r0, "R12 no read on overlap", n_rd - r0, 0);
        chk(n_wr == w0, "R12 no write on overlap", n_wr - w0, 0);
        chk(mem[8'h11] == DW'(8'h11 * 7 + 3), "R12 register untouched", mem[8'h11], DW'(8'h11 * 7 + 3));

        // R6: multiplexed address, both modes.
        mux_sel = 1; wait_n(4);
        mux_addr(8'h33); w0 = n_wr; m1_write(8'hEE, 8'h77); ale = 1; wait_n(3);
        chk(mem[8'h33] == 8'h77, "R6 mux write address", mem[8'h33], 8'h77);
        chk(mem[8'hEE] == DW'(8'hEE * 7 + 3), "R6 address pins ignored", mem[8'hEE], DW'(8'hEE * 7 + 3));
        bus_mode = 0; wait_n(4);
        mux_addr(8'h33); m0_read(8'hEE); ale = 1; wait_n(3);
        chk(data_out == 8'h77, "R6 mux read address", data_out, 8'h77);
        mux_sel = 0; wait_n(4);
        m0_read(8'h90);
        chk(data_out == 8'hC3, "R6 R8 pins again", data_out, 8'hC3);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule